// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

A 16-bit counter with a period register and a prescaler. It runs in one of four modes, chosen by three configuration bits. In timer mode it counts ticks of the internal clock. In gated timer mode it counts the same ticks, but only while an external gate input is high. In synchronous counter mode it counts edges of an external clock input. In asynchronous counter mode it counts the same edges without a synchronizer. The prescaler divides the selected source by 1, 8, 64 or 256. For the external source, the division takes place in the external clock's own domain, ahead of any synchronization.

When a counting step finds the count equal to the period value, the count returns to zero and a sticky interrupt flag is raised. In gated mode the flag comes instead from the end of each gate pulse. Software clears the flag with a one-cycle clear pulse. An enable bit freezes the count whenever it is low.

Top module: `tmr16_multi`

## Requirements
- R1: After the active-low reset, `count_o` is 0 and `flag_o` is 0.
- R2: With `clk_src_i`=0 and `gate_en_i`=0 (timer mode), the count advances once per prescaled internal clock tick, and the value of `sync_en_i` has no effect.
- R3: `pre_sel_i` selects the divide ratio: 2'b00 is /1, 2'b01 is /8, 2'b10 is /64 and 2'b11 is /256. In timer mode at /N, the count reaches k after k*N enabled clocks. The prescaler restarts from zero whenever `ton_i` is 0.
- R4: With `clk_src_i`=0 and `gate_en_i`=1 (gated mode), internal ticks are counted only while the gate, after a two-flop synchronizer, is high.
- R5: In gated mode, a falling edge of the synchronized gate sets `flag_o` one clock after that edge. A period match in gated mode clears the count but does not set the flag.
- R6: With `clk_src_i`=1 and `sync_en_i`=1, each falling edge of the prescaled external clock is counted after a two-flop synchronizer. The count therefore changes on the third internal clock edge after the external fall, and `gate_en_i` has no effect.
- R7: With `clk_src_i`=1 and `sync_en_i`=0, the prescaled external clock is sampled with no synchronizer. The count changes on the first internal clock edge after an external fall.
- R8: In every mode except gated, a counting step taken when `count_o` equals `period_i` sets `count_o` to 0 and sets `flag_o`. In every other step the count increases by one.
- R9: While `ton_i` is 0, `count_o` holds its value and `flag_o` does not rise.
- R10: `flag_o` stays set until a one-cycle `flag_clr_i` pulse clears it.
- R11: Between two clock edges, `count_o` stays the same, increases by one, or returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count clock |
| gate_i | input | 1 | External gate level |
| ton_i | input | 1 | Counting enable |
| clk_src_i | input | 1 | 0: internal ticks, 1: external clock |
| gate_en_i | input | 1 | Gated mode select (internal source only) |
| sync_en_i | input | 1 | Synchronize the external clock (external source only) |
| pre_sel_i | input | 2 | Prescale ratio select |
| period_i | input | 16 | Period value |
| flag_clr_i | input | 1 | Flag clear pulse |
| count_o | output | 16 | Current count |
| flag_o | output | 1 | Sticky interrupt flag |

## Verification
The bench measures how many internal clocks separate an external fall from the count step in the two counter modes. A design that swapped or dropped the synchronizer would step one cycle early or late. Gated runs check two things: a period wrap inside a gate pulse must not raise the flag, and a gate fall must raise it. A design that used the wrong flag source would show a mismatched flag. Each divide ratio is checked over an exact number of clocks, so a wrong encoding or an off-by-one terminal count changes the final count. A hold test checks the enable: a design that kept counting, or failed to freeze the prescaler, would show a different count.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned PRE_W = 8;
  localparam int unsigned IDX_W = $clog2(PRE_W);

  typedef enum logic [1:0] {
    MODE_TIMER,
    MODE_GATED,
    MODE_SYNC_CNT,
    MODE_ASYNC_CNT
  } mode_e;

  function automatic mode_e decode_mode(logic src, logic gate_en, logic sync_en);
    if (!src) return gate_en ? MODE_GATED : MODE_TIMER;
    return sync_en ? MODE_SYNC_CNT : MODE_ASYNC_CNT;
  endfunction

  // log2 of divide ratio: /1, /8, /64, /256
  function automatic int unsigned pre_shift(logic [1:0] sel);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 3;
      2'b10:   return 6;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/tmr16_sync2.sv
module tmr16_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tmr16_int_presc.sv
module tmr16_int_presc
  import tmr16_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       adv_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] term;
  logic             at_term;

  assign term    = PRE_W'((32'd1 << pre_shift(sel_i)) - 32'd1);
  assign at_term = (cnt_q == term);
  assign tick_o  = run_i & adv_i & at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (adv_i)   cnt_q <= at_term ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr16_ext_presc.sv
module tmr16_ext_presc
  import tmr16_pkg::*;
(
  input  logic       ext_clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       pre_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx;

  // falling edge of bit (shift-1) marks every 2**shift external edges
  assign idx   = IDX_W'(pre_shift(sel_i) - 1);
  assign pre_o = (sel_i == 2'b00) ? ext_clk_i : cnt_q[idx];

  always_ff @(posedge ext_clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
  import tmr16_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             gate_i,
  input  logic             ton_i,
  input  logic             clk_src_i,
  input  logic             gate_en_i,
  input  logic             sync_en_i,
  input  logic [1:0]       pre_sel_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  mode_e mode;
  logic  gated;
  logic  gate_s, gate_d;
  logic  pre_raw, pre_s, src_lvl, src_d, ext_fall;
  logic  int_tick, tick, match, match_set, gate_fall;
  logic [CNT_W-1:0] cnt_q;
  logic  flag_q;

  assign mode  = decode_mode(clk_src_i, gate_en_i, sync_en_i);
  assign gated = (mode == MODE_GATED);

  tmr16_sync2 u_gate_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gate_i),
    .q_o   (gate_s)
  );

  tmr16_ext_presc u_ext_presc (
    .ext_clk_i(ext_clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ton_i),
    .sel_i    (pre_sel_i),
    .pre_o    (pre_raw)
  );

  // synchronizer sits after the prescaler
  tmr16_sync2 u_ext_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pre_raw),
    .q_o   (pre_s)
  );

  tmr16_int_presc u_int_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (ton_i & ~clk_src_i),
    .adv_i (gated ? gate_s : 1'b1),
    .sel_i (pre_sel_i),
    .tick_o(int_tick)
  );

  assign src_lvl  = (mode == MODE_ASYNC_CNT) ? pre_raw : pre_s;
  assign ext_fall = src_d & ~src_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_d  <= 1'b0;
      gate_d <= 1'b0;
    end else begin
      src_d  <= src_lvl;
      gate_d <= gate_s;
    end
  end

  assign tick      = ton_i & (clk_src_i ? ext_fall : int_tick);
  assign match     = (cnt_q == period_i);
  assign match_set = tick & match & ~gated;
  assign gate_fall = ton_i & gated & gate_d & ~gate_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tick) cnt_q <= match ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (match_set || gate_fall) flag_q <= 1'b1;
    else if (flag_clr_i)             flag_q <= 1'b0;
  end

  assign count_o = cnt_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/tmr16_multi_chk.sv
module tmr16_multi_chk
  import tmr16_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ton_i,
  input logic             clk_src_i,
  input logic             gate_en_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o
);
  logic gated_cfg;
  assign gated_cfg = ~clk_src_i & gate_en_i;

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ton_i |=> $stable(count_o)); // R9

  AST_OFF_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ton_i && !flag_o) |=> !flag_o); // R9

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) + 16'd1) || (count_o == 16'd0))); // R11

  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ton_i) && !gated_cfg && ($past(count_o) != 16'd0) && (count_o == 16'd0)) |-> flag_o); // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(flag_clr_i)); // R10
endmodule

bind tmr16_multi tmr16_multi_chk u_chk (.*);

// File: tb/tmr16_multi_test.sv
module tmr16_multi_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk, rst_n, ext, gate, ton, src, gen, syn, clr;
  logic [1:0]  ps;
  logic [15:0] pr;
  logic [15:0] count;
  logic        flag;

  int n_chk = 0;
  int n_bad = 0;

  tmr16_multi uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext), .gate_i(gate), .ton_i(ton),
    .clk_src_i(src), .gate_en_i(gen), .sync_en_i(syn), .pre_sel_i(ps),
    .period_i(pr), .flag_clr_i(clr), .count_o(count), .flag_o(flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic        src, gen, syn;
    logic [1:0]  ps;
    logic [15:0] pr;
    logic [15:0] nclk;
    logic [15:0] npls;
    logic        gate;
    logic [15:0] ecnt;
    logic        eflag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b0,1'b0,1'b0, 2'd0, 16'd100, 16'd10,  16'd0,  1'b0, 16'd10, 1'b0}, // R2
    '{4'd2, 1'b0,1'b0,1'b1, 2'd0, 16'd100, 16'd10,  16'd0,  1'b0, 16'd10, 1'b0}, // R2 sync ignored
    '{4'd3, 1'b0,1'b0,1'b0, 2'd1, 16'd100, 16'd24,  16'd0,  1'b0, 16'd3,  1'b0}, // R3 /8
    '{4'd3, 1'b0,1'b0,1'b0, 2'd2, 16'd100, 16'd128, 16'd0,  1'b0, 16'd2,  1'b0}, // R3 /64
    '{4'd3, 1'b0,1'b0,1'b0, 2'd3, 16'd100, 16'd512, 16'd0,  1'b0, 16'd2,  1'b0}, // R3 /256
    '{4'd8, 1'b0,1'b0,1'b0, 2'd0, 16'd5,   16'd6,   16'd0,  1'b0, 16'd0,  1'b1}, // R8
    '{4'd8, 1'b0,1'b0,1'b0, 2'd0, 16'd5,   16'd8,   16'd0,  1'b0, 16'd2,  1'b1}, // R8
    '{4'd4, 1'b0,1'b1,1'b0, 2'd0, 16'd100, 16'd10,  16'd0,  1'b1, 16'd10, 1'b0}, // R4 gate high
    '{4'd4, 1'b0,1'b1,1'b0, 2'd0, 16'd100, 16'd10,  16'd0,  1'b0, 16'd0,  1'b0}, // R4 gate low
    '{4'd6, 1'b1,1'b1,1'b1, 2'd0, 16'd100, 16'd0,   16'd5,  1'b0, 16'd5,  1'b0}, // R6 gate_en ignored
    '{4'd7, 1'b1,1'b0,1'b0, 2'd0, 16'd100, 16'd0,   16'd5,  1'b0, 16'd5,  1'b0}, // R7
    '{4'd6, 1'b1,1'b0,1'b1, 2'd1, 16'd100, 16'd0,   16'd16, 1'b0, 16'd2,  1'b0}, // R6 /8
    '{4'd8, 1'b1,1'b0,1'b1, 2'd0, 16'd3,   16'd0,   16'd4,  1'b0, 16'd0,  1'b1}, // R8
    '{4'd7, 1'b1,1'b0,1'b0, 2'd1, 16'd100, 16'd0,   16'd8,  1'b0, 16'd1,  1'b0}  // R7 /8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ton = 1'b0; ext = 1'b0; clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ext_pulse();
    ext = 1'b1;
    repeat (3) @(negedge clk);
    ext = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(input logic s, input logic g, input logic y, input logic [1:0] p, input logic [15:0] per);
    src = s; gen = g; syn = y; ps = p; pr = per;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1; ext = 1'b0; gate = 1'b0; ton = 1'b0; clr = 1'b0;
    cfg(1'b0, 1'b0, 1'b0, 2'd0, 16'd100);

    // R1 reset state
    do_reset();
    @(negedge clk);
    check("R1 count", 32'(count), 32'd0);
    check("R1 flag", 32'(flag), 32'd0);

    foreach (VECS[i]) begin
      do_reset();
      cfg(VECS[i].src, VECS[i].gen, VECS[i].syn, VECS[i].ps, VECS[i].pr);
      gate = VECS[i].gate;
      repeat (3) @(negedge clk);
      ton = 1'b1;
      repeat (int'(VECS[i].nclk)) @(negedge clk);
      for (int k = 0; k < int'(VECS[i].npls); k++) ext_pulse();
      if (VECS[i].npls != 0) repeat (6) @(negedge clk);
      ton = 1'b0;
      @(negedge clk);
      check($sformatf("R%0d vec%0d count", VECS[i].req, i), 32'(count), 32'(VECS[i].ecnt));
      check($sformatf("R%0d vec%0d flag", VECS[i].req, i), 32'(flag), 32'(VECS[i].eflag));
    end

    // R1 reset mid-count
    do_reset();
    cfg(1'b0, 1'b0, 1'b0, 2'd0, 16'd100);
    ton = 1'b1;
    repeat (7) @(negedge clk);
    do_reset();
    @(negedge clk);
    check("R1 reset after run", 32'(count), 32'd0);

    // R5 gated: wrap without flag, gate fall sets flag
    do_reset();
    cfg(1'b0, 1'b1, 1'b0, 2'd0, 16'd2);
    gate = 1'b1;
    repeat (3) @(negedge clk);
    ton = 1'b1;
    repeat (7) @(negedge clk);
    check("R5 gated wrap count", 32'(count), 32'd1);
    check("R5 gated wrap no flag", 32'(flag), 32'd0);
    gate = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 flag not before sync", 32'(flag), 32'd0);
    @(negedge clk);
    check("R5 gate fall flag", 32'(flag), 32'd1);
    check("R4 count frozen at gate low", 32'(count), 32'd0);
    repeat (4) @(negedge clk);
    check("R4 gate low no count", 32'(count), 32'd0);

    // R10 sticky flag, clear pulse
    check("R10 flag sticky", 32'(flag), 32'd1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R10 flag cleared", 32'(flag), 32'd0);
    ton = 1'b0;

    // R9 hold while disabled
    do_reset();
    cfg(1'b0, 1'b0, 1'b0, 2'd0, 16'd100);
    ton = 1'b1;
    repeat (5) @(negedge clk);
    ton = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 hold count", 32'(count), 32'd5);
    check("R9 no flag", 32'(flag), 32'd0);
    ton = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 resume", 32'(count), 32'd7);
    ton = 1'b0;

    // R3 prescaler restarts after disable: /8, 5 clocks, off, then 8 more -> 1
    do_reset();
    cfg(1'b0, 1'b0, 1'b0, 2'd1, 16'd100);
    ton = 1'b1;
    repeat (5) @(negedge clk);
    ton = 1'b0;
    @(negedge clk);
    ton = 1'b1;
    repeat (7) @(negedge clk);
    check("R3 presc cleared early", 32'(count), 32'd0);
    @(negedge clk);
    check("R3 presc cleared tick", 32'(count), 32'd1);
    ton = 1'b0;

    // R6 sync latency: third edge after fall
    do_reset();
    cfg(1'b1, 1'b0, 1'b1, 2'd0, 16'd100);
    ton = 1'b1;
    ext = 1'b1;
    repeat (3) @(negedge clk);
    ext = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 sync not yet", 32'(count), 32'd0);
    @(negedge clk);
    check("R6 sync counted", 32'(count), 32'd1);
    ton = 1'b0;

    // R7 async latency: first edge after fall
    do_reset();
    cfg(1'b1, 1'b0, 1'b0, 2'd0, 16'd100);
    ton = 1'b1;
    ext = 1'b1;
    repeat (3) @(negedge clk);
    ext = 1'b0;
    @(negedge clk);
    check("R7 async counted", 32'(count), 32'd1);
    ton = 1'b0;

    // R11 / R8 long wrap sequence, period 2, count reads 0,1,2,0
    do_reset();
    cfg(1'b0, 1'b0, 1'b0, 2'd0, 16'd2);
    ton = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check($sformatf("R11 step %0d", k), 32'(count), 32'(k % 3));
    end
    check("R8 flag after wrap", 32'(flag), 32'd1);
    ton = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule